// File: doc/BRIEF.md
# Arithmetic-logic unit with packed status word

This block performs one arithmetic or logic operation per accepted request on 8-bit or 16-bit operands. It returns the result together with the condition bits that the operation produced. Inside, it keeps a 16-bit status word. That word holds six condition bits and three control bits.

Requests arrive on a valid/ready stream and leave on a second valid/ready stream. The output stage is a single register. A new request is taken whenever that register is empty or is being drained in the same cycle. While the consumer holds `out_ready` low, the result and its flags stay frozen and no new request is accepted.

The condition bits of the status word are written only when a request is accepted with `flag_we` high and its operation is one that produces flags. The three control bits have their own plain set and clear strobes, which act in every cycle.

Top module: `alu16_flags`

## Requirements
- R1: Operation codes are 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 increment, 6 decrement, 7 complement and 8 shift-left-by-one. Codes 9 to 15 pass `op_a` through and produce no flags. For add, carry is the carry out of the top bit of the selected width. For subtract, carry is the borrow, set when `op_a` is below `op_b` as unsigned numbers.
- R2: For add, subtract, increment and decrement, auxiliary carry is set when a carry or borrow crosses from bit 3 into bit 4.
- R3: For add, subtract, increment and decrement, overflow is set when the signed result does not fit the selected width. For shift, overflow is the new top bit XOR the carry.
- R4: Zero is set when the result in the selected width is all zeros. Sign copies the top bit of the selected width. Parity is set when the low 8 result bits hold an even number of ones.
- R5: AND, OR and XOR clear carry, overflow and auxiliary carry.
- R6: Increment and decrement leave the stored carry bit unchanged, and `out_flags` reports that stored carry.
- R7: Complement returns the bitwise inverse of `op_a` in the selected width. It never changes the status word, and `out_flags` repeats the stored condition bits.
- R8: Shift moves `op_a` left by one and fills bit 0 with zero. Carry takes the bit shifted out, and auxiliary carry is cleared.
- R9: With `wide` low, the operation works on bits 7:0 only, the upper result byte is zero, and carry, sign and overflow refer to bit 7.
- R10: The status word has carry at bit 0, parity at 2, auxiliary carry at 4, zero at 6, sign at 7, trap at 8, interrupt enable at 9, direction at 10 and overflow at 11, and all other bits read zero. Condition bits change only when a flag-producing request is accepted with `flag_we` high, one cycle after acceptance.
- R11: Each control bit is set by its set strobe and cleared by its clear strobe on the next edge. When both strobes are high, clear wins.
- R12: `in_ready` is high when the output register is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_result` and `out_flags` hold.
- R13: After reset, the status word is zero and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| op_code | input | 4 | Operation select |
| wide | input | 1 | 1 = 16-bit, 0 = 8-bit |
| flag_we | input | 1 | Allow the request to write the condition bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 16 | Result |
| out_flags | output | 16 | Condition bits belonging to the result, in status-word layout |
| tf_set | input | 1 | Set trap bit |
| tf_clr | input | 1 | Clear trap bit |
| ie_set | input | 1 | Set interrupt-enable bit |
| ie_clr | input | 1 | Clear interrupt-enable bit |
| df_set | input | 1 | Set direction bit |
| df_clr | input | 1 | Clear direction bit |
| flag_word | output | 16 | Stored status word |

## Verification
The hardest case to reach is a request accepted while the output register is held full. The same case also covers increment or decrement running against a carry value left behind by an earlier operation. Random draws of operands seldom land on the narrow boundaries: 0x7FFF, 0xFFFF, 0x0F, 0x80 and zero in byte mode. For that reason, a directed sequence first chains carry-producing adds, then increments, decrements and complements, and then byte-mode boundary values. After that, a long random phase mixes back-pressure, biased boundary operands, reserved codes, disabled flag writes and simultaneous set/clear strobes. A behavioural model checks every cycle of both phases.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_INC = 4'd5,
    OP_DEC = 4'd6,
    OP_NOT = 4'd7,
    OP_SHL = 4'd8
  } alu_op_e;

  localparam int STAT_W   = 16;
  localparam int POS_CF   = 0;
  localparam int POS_PF   = 2;
  localparam int POS_AF   = 4;
  localparam int POS_ZF   = 6;
  localparam int POS_SF   = 7;
  localparam int POS_TF   = 8;
  localparam int POS_IE   = 9;
  localparam int POS_DF   = 10;
  localparam int POS_OF   = 11;
  localparam int NUM_CTL  = 3;

  localparam logic [STAT_W-1:0] COND_MASK =
    STAT_W'((1 << POS_CF) | (1 << POS_PF) | (1 << POS_AF) |
            (1 << POS_ZF) | (1 << POS_SF) | (1 << POS_OF));
endpackage

// File: rtl/alu16_datapath.sv
module alu16_datapath
  import alu16_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic [3:0]        op_i,
  input  logic              wide_i,
  input  logic              cf_i,
  input  logic [STAT_W-1:0] cur_cond_i,
  output logic [WORD_W-1:0] res_o,
  output logic [STAT_W-1:0] cond_o,
  output logic              writes_o
);
  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] mask, am, bm, rhs, ar, shr, aux_vec, r;
  logic [WORD_W:0]   ext;
  logic is_sub, is_arith, is_logic, is_step;
  logic top_a, top_rhs, top_ar, top_shr, top_r;
  logic arith_cy, arith_ov;
  logic cy, aux, ovf, zf, sf, pf;

  always_comb begin
    mask     = wide_i ? {WORD_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    am       = a_i & mask;
    bm       = b_i & mask;
    is_step  = (op_i == OP_INC) || (op_i == OP_DEC);
    is_sub   = (op_i == OP_SUB) || (op_i == OP_DEC);
    is_arith = (op_i == OP_ADD) || (op_i == OP_SUB) || is_step;
    is_logic = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR);
    rhs      = is_step ? WORD_W'(1) : bm;
    ext      = is_sub ? ({1'b0, am} - {1'b0, rhs}) : ({1'b0, am} + {1'b0, rhs});
    ar       = ext[WORD_W-1:0] & mask;
    aux_vec  = am ^ rhs ^ ext[WORD_W-1:0];
    shr      = (am << 1) & mask;

    top_a    = wide_i ? am[WORD_W-1]  : am[HALF_W-1];
    top_rhs  = wide_i ? rhs[WORD_W-1] : rhs[HALF_W-1];
    top_ar   = wide_i ? ar[WORD_W-1]  : ar[HALF_W-1];
    top_shr  = wide_i ? shr[WORD_W-1] : shr[HALF_W-1];
    arith_cy = wide_i ? ext[WORD_W] : ext[HALF_W];
    arith_ov = is_sub ? ((top_a != top_rhs) && (top_ar != top_a))
                      : ((top_a == top_rhs) && (top_ar != top_a));

    r   = am;
    cy  = 1'b0;
    aux = 1'b0;
    ovf = 1'b0;
    if (is_arith) begin
      r   = ar;
      cy  = is_step ? cf_i : arith_cy;
      aux = aux_vec[4];
      ovf = arith_ov;
    end else if (is_logic) begin
      case (op_i)
        OP_AND:  r = am & bm;
        OP_OR:   r = am | bm;
        default: r = am ^ bm;
      endcase
    end else if (op_i == OP_SHL) begin
      r   = shr;
      cy  = top_a;
      ovf = top_shr ^ top_a;
    end else if (op_i == OP_NOT) begin
      r = ~am & mask;
    end

    top_r = wide_i ? r[WORD_W-1] : r[HALF_W-1];
    zf    = (r == '0);
    sf    = top_r;
    pf    = ~^r[7:0];

    writes_o = is_arith || is_logic || (op_i == OP_SHL);
    res_o    = r;
    if (writes_o) begin
      cond_o         = '0;
      cond_o[POS_CF] = cy;
      cond_o[POS_PF] = pf;
      cond_o[POS_AF] = aux;
      cond_o[POS_ZF] = zf;
      cond_o[POS_SF] = sf;
      cond_o[POS_OF] = ovf;
    end else begin
      cond_o = cur_cond_i & COND_MASK;
    end
  end

  always_comb begin
    if (!wide_i) assert (res_o[WORD_W-1:HALF_W] == '0)
      else $error("p_byte_upper_zero_r9");
  end
endmodule

// File: rtl/alu16_statreg.sv
module alu16_statreg
  import alu16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] cond_i,
  input  logic [NUM_CTL-1:0] set_i,
  input  logic [NUM_CTL-1:0] clr_i,
  output logic [STAT_W-1:0] stat_o
);
  localparam int CTL_POS [NUM_CTL] = '{POS_TF, POS_IE, POS_DF};

  logic [STAT_W-1:0] stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (wr_en_i) stat_d = (stat_q & ~COND_MASK) | (cond_i & COND_MASK);
    for (int k = 0; k < NUM_CTL; k++) begin
      if (clr_i[k])      stat_d[CTL_POS[k]] = 1'b0;
      else if (set_i[k]) stat_d[CTL_POS[k]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  p_clr_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i[1] |=> !stat_q[POS_IE]);
  p_set_ie_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i[1] && !clr_i[1]) |=> stat_q[POS_IE]);
  p_cond_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> ((stat_q & COND_MASK) == ($past(stat_q) & COND_MASK)));
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
  import alu16_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic [3:0]        op_code,
  input  logic              wide,
  input  logic              flag_we,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_result,
  output logic [STAT_W-1:0] out_flags,
  input  logic              tf_set,
  input  logic              tf_clr,
  input  logic              ie_set,
  input  logic              ie_clr,
  input  logic              df_set,
  input  logic              df_clr,
  output logic [STAT_W-1:0] flag_word
);
  logic              accept, writes;
  logic [WORD_W-1:0] res_d, res_q;
  logic [STAT_W-1:0] cond_d, cond_q, stat;
  logic              ov_q;

  assign in_ready = !ov_q || out_ready;
  assign accept   = in_valid && in_ready;

  alu16_datapath #(.WORD_W(WORD_W)) i_dp (
    .a_i       (op_a),
    .b_i       (op_b),
    .op_i      (op_code),
    .wide_i    (wide),
    .cf_i      (stat[POS_CF]),
    .cur_cond_i(stat),
    .res_o     (res_d),
    .cond_o    (cond_d),
    .writes_o  (writes)
  );

  alu16_statreg i_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en_i(accept && flag_we && writes),
    .cond_i (cond_d),
    .set_i  ({df_set, ie_set, tf_set}),
    .clr_i  ({df_clr, ie_clr, tf_clr}),
    .stat_o (stat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_q   <= 1'b0;
      res_q  <= '0;
      cond_q <= '0;
    end else if (accept) begin
      ov_q   <= 1'b1;
      res_q  <= res_d;
      cond_q <= cond_d;
    end else if (out_ready) begin
      ov_q   <= 1'b0;
    end
  end

  assign out_valid  = ov_q;
  assign out_result = res_q;
  assign out_flags  = cond_q;
  assign flag_word  = stat;

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && !out_ready) |=> (ov_q && $stable(res_q) && $stable(cond_q)));
  p_step_keeps_cf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op_code == OP_INC || op_code == OP_DEC))
      |=> (stat[POS_CF] == $past(stat[POS_CF])));
  p_not_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_code == OP_NOT) |=> ((stat & COND_MASK) == ($past(stat) & COND_MASK)));
  p_undef_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & ~(COND_MASK | STAT_W'(16'h0700))) == '0);
endmodule

// File: tb/test_alu16_flags.sv
`timescale 1ns/1ps
module test_alu16_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b1, wide = 1'b1, flag_we = 1'b1;
  logic [15:0] op_a = '0, op_b = '0;
  logic [3:0]  op_code = '0;
  logic        tf_set = 0, tf_clr = 0, ie_set = 0, ie_clr = 0, df_set = 0, df_clr = 0;
  logic        in_ready, out_valid;
  logic [15:0] out_result, out_flags, flag_word;

  int checks = 0, errors = 0;
  bit run_checks = 0;

  always #2.5 clk = ~clk;

  alu16_flags i_alu16_flags (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .op_code(op_code), .wide(wide), .flag_we(flag_we),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_flags(out_flags), .tf_set(tf_set), .tf_clr(tf_clr), .ie_set(ie_set),
    .ie_clr(ie_clr), .df_set(df_set), .df_clr(df_clr), .flag_word(flag_word)
  );

  // Behavioural reference model
  logic [15:0] m_flag, m_res, m_cond;
  logic        m_ov;
  int          m_op;
  logic        m_wide;

  task automatic calc(input int op, input int a, input int b, input bit wd,
                      input logic [15:0] cur, output logic [15:0] res,
                      output logic [15:0] cond, output bit wr);
    int w, mask, msb, am, bm, r, sa, sb, s;
    bit c, af, ov, arith;
    w = wd ? 16 : 8;
    mask = (1 << w) - 1;
    msb = 1 << (w - 1);
    am = a & mask;
    bm = b & mask;
    c = 0; af = 0; ov = 0; wr = 1; arith = 0;
    if (op == 5 || op == 6) bm = 1;
    sa = (am >= msb) ? am - (1 << w) : am;
    sb = (bm >= msb) ? bm - (1 << w) : bm;
    case (op)
      0, 5: begin
        r = (am + bm) & mask; c = (am + bm) > mask;
        af = ((am & 15) + (bm & 15)) > 15;
        s = sa + sb; ov = (s >= msb) || (s < -msb); arith = 1;
      end
      1, 6: begin
        r = (am - bm) & mask; c = am < bm;
        af = (am & 15) < (bm & 15);
        s = sa - sb; ov = (s >= msb) || (s < -msb); arith = 1;
      end
      2: r = am & bm;
      3: r = am | bm;
      4: r = am ^ bm;
      7: begin r = ~am & mask; wr = 0; end
      8: begin
        r = (am << 1) & mask; c = (am & msb) != 0;
        ov = ((r & msb) != 0) ^ c;
      end
      default: begin r = am; wr = 0; end
    endcase
    if (op == 5 || op == 6) c = cur[0];   // R6
    res = r[15:0];
    if (wr) begin
      cond = '0;
      cond[0]  = c;
      cond[2]  = ($countones(r & 255) % 2) == 0;
      cond[4]  = af;
      cond[6]  = (r == 0);
      cond[7]  = (r & msb) != 0;
      cond[11] = ov;
    end else begin
      cond = cur & 16'h08D5;
    end
  endtask

  always @(posedge clk) begin
    logic [15:0] nr, nc, nf;
    bit w;
    if (!rst_n) begin
      m_flag = '0; m_ov = 0; m_res = '0; m_cond = '0;
    end else begin
      nf = m_flag;
      if (in_valid && (!m_ov || out_ready)) begin
        calc(op_code, op_a, op_b, wide, m_flag, nr, nc, w);
        if (flag_we && w) nf = (m_flag & ~16'h08D5) | nc;
        m_res = nr; m_cond = nc; m_ov = 1; m_op = op_code; m_wide = wide;
      end else if (out_ready) m_ov = 0;
      if (tf_clr) nf[8] = 0;  else if (tf_set) nf[8] = 1;
      if (ie_clr) nf[9] = 0;  else if (ie_set) nf[9] = 1;
      if (df_clr) nf[10] = 0; else if (df_set) nf[10] = 1;
      m_flag = nf;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string res_tag(int op, bit wd);
    if (!wd) return "R9 result";
    if (op == 7) return "R7 result";
    if (op == 8) return "R8 result";
    if (op >= 2 && op <= 4) return "R5 result";
    return "R1 result";
  endfunction

  function automatic string cf_tag(int op);
    if (op == 5 || op == 6) return "R6 carry";
    if (op >= 2 && op <= 4) return "R5 carry";
    if (op == 8) return "R8 carry";
    if (op == 7) return "R7 carry";
    return "R1 carry";
  endfunction

  always @(negedge clk) begin
    if (run_checks) begin
      chk("R12 out_valid", out_valid, m_ov);
      chk("R12 in_ready", in_ready, !m_ov || out_ready);
      chk("R10 condition bits", flag_word & 16'hF8FF, m_flag & 16'hF8FF);
      chk("R11 control bits", flag_word & 16'h0700, m_flag & 16'h0700);
      if (m_ov) begin
        chk(res_tag(m_op, m_wide), out_result, m_res);
        chk(cf_tag(m_op), out_flags[0], m_cond[0]);
        chk("R2 aux carry", out_flags[4], m_cond[4]);
        chk("R3 overflow", out_flags[11], m_cond[11]);
        chk("R4 zero", out_flags[6], m_cond[6]);
        chk("R4 sign", out_flags[7], m_cond[7]);
        chk("R4 parity", out_flags[2], m_cond[2]);
        chk("R10 unused bits", out_flags & 16'hF72A, 0);
      end
    end
  end

  task automatic send(input int op, input int a, input int b, input bit wd, input bit we);
    @(negedge clk); #1;
    op_code = 4'(op); op_a = 16'(a); op_b = 16'(b); wide = wd; flag_we = we;
    in_valid = 1;
    do @(posedge clk); while (!in_ready);
    #1 in_valid = 0;
  endtask

  function automatic int pick();
    case ($urandom_range(0, 7))
      0: return 16'h7FFF;
      1: return 16'hFFFF;
      2: return 16'h8000;
      3: return 16'h000F;
      4: return 16'h0080;
      5: return 0;
      default: return int'($urandom_range(0, 65535));
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R13 reset flag word", flag_word, 0);
    chk("R13 reset out_valid", out_valid, 0);
    run_checks = 1;
    // directed corners
    send(0, 16'hFFFF, 1, 1, 1);        // carry + zero
    send(5, 16'h7FFF, 0, 1, 1);        // R6: inc keeps carry=1, overflow
    send(6, 16'h8000, 0, 1, 1);        // dec overflow, carry kept
    send(0, 16'h000F, 1, 1, 1);        // R2 aux carry
    send(1, 16'h0010, 1, 1, 1);        // R2 aux borrow
    send(1, 3, 5, 1, 1);               // R1 borrow
    send(7, 16'h1234, 0, 1, 1);        // R7 no write
    send(2, 16'hF0F0, 16'h0FF0, 1, 1); // R5
    send(8, 16'h8001, 0, 1, 1);        // R8
    send(0, 16'h1280, 16'h3480, 0, 1); // R9 byte carry
    send(1, 16'h0080, 1, 0, 1);        // R9 byte overflow
    send(6, 0, 0, 0, 1);               // byte dec wrap
    send(0, 1, 1, 1, 0);               // R10 no write
    send(12, 16'hABCD, 0, 1, 1);       // reserved code
    @(negedge clk); #1 ie_set = 1; ie_clr = 1; tf_set = 1; df_set = 1;
    @(negedge clk); #1 ie_set = 1; ie_clr = 0; tf_clr = 1; tf_set = 0; df_set = 0;
    @(negedge clk); #1 ie_set = 0; tf_clr = 0;
    // random phase with back-pressure
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk); #1;
      in_valid  = $urandom_range(0, 3) != 0;
      out_ready = $urandom_range(0, 9) < 7;
      op_code   = 4'($urandom_range(0, 15) < 13 ? $urandom_range(0, 8) : $urandom_range(9, 15));
      op_a      = 16'(pick());
      op_b      = 16'(pick());
      wide      = $urandom_range(0, 2) != 0;
      flag_we   = $urandom_range(0, 4) != 0;
      tf_set = $urandom_range(0, 7) == 0; tf_clr = $urandom_range(0, 7) == 0;
      ie_set = $urandom_range(0, 7) == 0; ie_clr = $urandom_range(0, 7) == 0;
      df_set = $urandom_range(0, 7) == 0; df_clr = $urandom_range(0, 7) == 0;
    end
    @(negedge clk); #1 in_valid = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    run_checks = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule